// File: doc/BRIEF.md
# Transfer Count and Address Sequencer

This block keeps the per-channel state of a data transfer controller: a 24-bit source address, a 24-bit destination address and a 16-bit count word. Software presents the initial values together with a mode and an access size on the load inputs and pulses `load`. After that, every `xfer` strobe stands for one completed data move. On each strobe the block moves the count and both addresses on by one step.

In normal mode the whole count word is one down-counter. A one-cycle `done` pulse marks the end of the sequence. Once the sequence has ended, the block ignores further strobes until the next load. In repeat and block modes the count word splits into two bytes. The high byte is a fixed reload value and the low byte is the running counter. When the low byte runs out, it refills from the high byte and a one-cycle `reload` pulse fires. At the same moment one chosen address goes back to its loaded value. This refill repeats without end. A word-size access with an odd source or destination address raises `align_err`.

Top module: `dtc_xfer_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the addresses, the count, `active`, `done`, `reload` and `align_err`, and selects normal mode with byte size.
- R2: A cycle with `load` high copies `ld_src`, `ld_dst`, `ld_count` and the configuration into the block and sets `active` to 1 from the next cycle on.
- R3: `ld_mode` encoding: 00 is normal, 01 is repeat, 10 is block and 11 acts as repeat. In normal mode each accepted strobe decrements the 16-bit count by one. A loaded count of 0 wraps to 0xFFFF, so it gives 65,536 transfers.
- R4: In normal mode, the strobe that brings the count to 0 makes `active` low and `done` high in the following cycle. `done` stays high for exactly that one cycle.
- R5: While `active` is low, `xfer` changes neither the count nor the addresses and produces no pulse.
- R6: In repeat and block modes each strobe decrements bits 7:0 and leaves bits 15:8 unchanged. A strobe that finds bits 7:0 equal to 1 copies bits 15:8 into bits 7:0 and gives a one-cycle `reload` pulse. A low byte of 0 counts as 256. `active` stays high.
- R7: On each accepted strobe, an address whose increment enable is set advances by 1 for byte size (`ld_word`=0) or by 2 for word size (`ld_word`=1), wrapping at 24 bits. An address without its enable holds.
- R8: In repeat and block modes, on a reload strobe, the address picked by `ld_area_dst` (1 picks the destination, 0 picks the source) returns to its loaded value instead of advancing.
- R9: `align_err` is high exactly when word size is configured and bit 0 of the current source or destination address is 1.
- R10: When `load` and `xfer` are both high in the same cycle, the load wins and no decrement or address step takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe for the addresses, count and configuration |
| ld_src | input | 24 | Source address to load |
| ld_dst | input | 24 | Destination address to load |
| ld_count | input | 16 | Count word to load |
| ld_mode | input | 2 | Mode: 00 normal, 01 repeat, 10 block, 11 repeat |
| ld_word | input | 1 | 1 selects word size, 0 selects byte size |
| ld_src_inc | input | 1 | Source address increment enable |
| ld_dst_inc | input | 1 | Destination address increment enable |
| ld_area_dst | input | 1 | Address restored on reload: 1 destination, 0 source |
| xfer | input | 1 | One completed transfer |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| count | output | 16 | Current count word |
| active | output | 1 | Sequence running; strobes are accepted |
| done | output | 1 | One-cycle pulse at the end of a normal-mode sequence |
| reload | output | 1 | One-cycle pulse when the low counter refills |
| align_err | output | 1 | Word size with an odd address |

## Verification
The bench loads a count of zero and runs all 65,536 strobes. A design that treats zero as empty would end at once. A design that stops one strobe early or late would pulse `done` on the wrong strobe. A repeat run with a zero high byte and a zero low byte must reload after exactly 256 strobes. An off-by-one in the refill would shift every later reload, and a design that reloads on a low byte of zero instead of one would skip a count. A set of short sequences checks that strobes after the end leave the state alone, and that a load coinciding with a strobe wins. It also checks that only the selected address snaps back on a reload, and that a word address at the top of the 24-bit range wraps rather than carries out.

// File: rtl/dtc_xfer_pkg.sv
package dtc_xfer_pkg;

    typedef enum logic [1:0] {
        XM_NORMAL = 2'b00,
        XM_REPEAT = 2'b01,
        XM_BLOCK  = 2'b10,
        XM_ALTREP = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       word;
        logic       src_inc;
        logic       dst_inc;
        logic       area_dst;
    } xfer_cfg_t;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;

    // Raw mode code to enum; the spare code behaves as repeat.
    function automatic xfer_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'b00:   return XM_NORMAL;
            2'b01:   return XM_REPEAT;
            2'b10:   return XM_BLOCK;
            default: return XM_REPEAT;
        endcase
    endfunction

    // Repeat and block modes share the split-counter behaviour.
    function automatic logic is_cyclic(input xfer_mode_e m);
        return m != XM_NORMAL;
    endfunction

endpackage

// File: rtl/dtc_count_unit.sv
module dtc_count_unit
    import dtc_xfer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_count,
    input  logic             cyclic,
    input  logic             xfer,
    output logic [CNT_W-1:0] count_q,
    output logic             active_q,
    output logic             done_q,
    output logic             reload_q,
    output logic             step,
    output logic             reload_now
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0]  lo, hi;
    logic             lo_last;
    logic             end_now;
    logic [CNT_W-1:0] count_next;

    assign lo      = count_q[HALF-1:0];
    assign hi      = count_q[CNT_W-1:HALF];
    assign lo_last = (lo == HALF'(1));

    // A strobe counts only while running and not overridden by a load.
    assign step       = xfer & active_q & ~load;
    assign reload_now = step & cyclic & lo_last;
    assign end_now    = step & ~cyclic & (count_q == CNT_W'(1));

    always_comb begin
        if (cyclic) begin
            count_next = {hi, (lo_last ? hi : lo - HALF'(1))};
        end else begin
            count_next = count_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            done_q   <= end_now;
            reload_q <= reload_now;
            if (load) begin
                count_q  <= ld_count;
                active_q <= 1'b1;
            end else if (step) begin
                count_q <= count_next;
                if (end_now) begin
                    active_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dtc_addr_unit.sv
module dtc_addr_unit #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_inc,
    input  logic              ld_restore,
    input  logic              word,
    input  logic              step,
    input  logic              reload_now,
    output logic [ADDR_W-1:0] addr_q
);
    logic [ADDR_W-1:0] base_q;
    logic              inc_q;
    logic              restore_q;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] addr_next;

    assign stride = word ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        if (reload_now && restore_q) begin
            addr_next = base_q;
        end else if (inc_q) begin
            addr_next = addr_q + stride;
        end else begin
            addr_next = addr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            base_q    <= '0;
            inc_q     <= 1'b0;
            restore_q <= 1'b0;
        end else if (load) begin
            addr_q    <= ld_addr;
            base_q    <= ld_addr;
            inc_q     <= ld_inc;
            restore_q <= ld_restore;
        end else if (step) begin
            addr_q <= addr_next;
        end
    end

endmodule

// File: rtl/dtc_xfer_unit.sv
module dtc_xfer_unit
    import dtc_xfer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [1:0]        ld_mode,
    input  logic              ld_word,
    input  logic              ld_src_inc,
    input  logic              ld_dst_inc,
    input  logic              ld_area_dst,
    input  logic              xfer,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output logic              active,
    output logic              done,
    output logic              reload,
    output logic              align_err
);
    xfer_cfg_t         cfg_q;
    xfer_mode_e        ld_mode_e;
    logic              ld_cyclic;
    logic              step;
    logic              reload_now;
    logic [ADDR_W-1:0] side_ld   [NUM_SIDES];
    logic              side_inc  [NUM_SIDES];
    logic              side_rest [NUM_SIDES];
    logic [ADDR_W-1:0] side_addr [NUM_SIDES];

    assign ld_mode_e = decode_mode(ld_mode);
    assign ld_cyclic = is_cyclic(ld_mode_e);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: XM_NORMAL, word: 1'b0, src_inc: 1'b0,
                       dst_inc: 1'b0, area_dst: 1'b0};
        end else if (load) begin
            cfg_q <= '{mode: ld_mode_e, word: ld_word, src_inc: ld_src_inc,
                       dst_inc: ld_dst_inc, area_dst: ld_area_dst};
        end
    end

    dtc_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .ld_count   (ld_count),
        .cyclic     (is_cyclic(cfg_q.mode)),
        .xfer       (xfer),
        .count_q    (count),
        .active_q   (active),
        .done_q     (done),
        .reload_q   (reload),
        .step       (step),
        .reload_now (reload_now)
    );

    assign side_ld[SIDE_SRC]   = ld_src;
    assign side_ld[SIDE_DST]   = ld_dst;
    assign side_inc[SIDE_SRC]  = ld_src_inc;
    assign side_inc[SIDE_DST]  = ld_dst_inc;
    assign side_rest[SIDE_SRC] = ld_cyclic & ~ld_area_dst;
    assign side_rest[SIDE_DST] = ld_cyclic &  ld_area_dst;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        dtc_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .ld_addr    (side_ld[g]),
            .ld_inc     (side_inc[g]),
            .ld_restore (side_rest[g]),
            .word       (cfg_q.word),
            .step       (step),
            .reload_now (reload_now),
            .addr_q     (side_addr[g])
        );
    end

    assign src_addr  = side_addr[SIDE_SRC];
    assign dst_addr  = side_addr[SIDE_DST];
    assign align_err = cfg_q.word & (src_addr[0] | dst_addr[0]);

endmodule

// File: rtl/dtc_xfer_checker.sv
module dtc_xfer_checker #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic              ld_word,
    input logic [ADDR_W-1:0] ld_src,
    input logic [CNT_W-1:0]  ld_count,
    input logic              xfer,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  count,
    input logic              active,
    input logic              done,
    input logic              reload,
    input logic              align_err,
    input logic              cyclic,
    input logic              word,
    input logic              src_inc
);
    localparam int HALF = CNT_W / 2;

    p_normal_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && !load && !cyclic) |=> (count == $past(count) - CNT_W'(1)));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_end_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && count == '0));

    p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
        (!active && xfer && !load) |=>
            ($stable(count) && $stable(src_addr) && $stable(dst_addr) && !done && !reload));

    p_reload_copy_r6: assert property (@(posedge clk) disable iff (rst)
        reload |-> (count[HALF-1:0] == count[CNT_W-1:HALF]));

    p_cyclic_run_r6: assert property (@(posedge clk) disable iff (rst)
        (active && cyclic) |=> active);

    p_src_step_r7: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && !load && !cyclic && src_inc) |=>
            (src_addr == $past(src_addr) + (word ? ADDR_W'(2) : ADDR_W'(1))));

    p_align_r9: assert property (@(posedge clk) disable iff (rst)
        (load && ld_word && ld_src[0]) |=> align_err);

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (active && count == $past(ld_count) && src_addr == $past(ld_src)));

endmodule

bind dtc_xfer_unit dtc_xfer_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ld_word   (ld_word),
    .ld_src    (ld_src),
    .ld_count  (ld_count),
    .xfer      (xfer),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .count     (count),
    .active    (active),
    .done      (done),
    .reload    (reload),
    .align_err (align_err),
    .cyclic    (cfg_q.mode != dtc_xfer_pkg::XM_NORMAL),
    .word      (cfg_q.word),
    .src_inc   (cfg_q.src_inc)
);

// File: tb/tb_dtc_xfer_unit.sv
module tb_dtc_xfer_unit;
    localparam int AW = 24;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic [AW-1:0] ld_src = '0, ld_dst = '0;
    logic [CW-1:0] ld_count = '0;
    logic [1:0]    ld_mode = 2'b00;
    logic          ld_word = 1'b0, ld_src_inc = 1'b0, ld_dst_inc = 1'b0, ld_area_dst = 1'b0;
    logic          xfer = 1'b0;
    logic [AW-1:0] src_addr, dst_addr;
    logic [CW-1:0] count;
    logic          active, done, reload, align_err;

    int vectors = 0;
    int miscompares = 0;

    // Expected state
    logic [AW-1:0] m_src, m_dst, b_src, b_dst;
    logic [CW-1:0] m_cnt;
    logic m_active, m_done, m_reload, m_word, m_sinc, m_dinc, m_area, m_cyc;

    always #5 clk = ~clk;

    dtc_xfer_unit dut (
        .clk(clk), .rst(rst), .load(load), .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_count(ld_count), .ld_mode(ld_mode), .ld_word(ld_word),
        .ld_src_inc(ld_src_inc), .ld_dst_inc(ld_dst_inc), .ld_area_dst(ld_area_dst),
        .xfer(xfer), .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
        .active(active), .done(done), .reload(reload), .align_err(align_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "src_addr", 32'(src_addr), 32'(m_src));
        chk(tag, "dst_addr", 32'(dst_addr), 32'(m_dst));
        chk(tag, "count", 32'(count), 32'(m_cnt));
        chk(tag, "active", 32'(active), 32'(m_active));
        chk(tag, "done", 32'(done), 32'(m_done));
        chk(tag, "reload", 32'(reload), 32'(m_reload));
        chk("R9", "align_err", 32'(align_err), 32'(m_word & (m_src[0] | m_dst[0])));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic do_load(input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input logic [CW-1:0] c, input logic [1:0] mode,
                           input logic w, input logic si, input logic di,
                           input logic area, input logic with_xfer);
        @(negedge clk);
        load = 1'b1; ld_src = s; ld_dst = d; ld_count = c; ld_mode = mode;
        ld_word = w; ld_src_inc = si; ld_dst_inc = di; ld_area_dst = area;
        xfer = with_xfer;
        @(posedge clk);
        #1;
        load = 1'b0; xfer = 1'b0;
        m_src = s; m_dst = d; b_src = s; b_dst = d; m_cnt = c;
        m_active = 1'b1; m_done = 1'b0; m_reload = 1'b0;
        m_word = w; m_sinc = si; m_dinc = di; m_area = area; m_cyc = (mode != 2'b00);
        check_all(with_xfer ? "R10" : "R2");
    endtask

    task automatic model_step();
        logic [7:0] lo, hi;
        logic [AW-1:0] stride;
        m_done = 1'b0;
        m_reload = 1'b0;
        if (!m_active) return;
        stride = m_word ? AW'(2) : AW'(1);
        if (m_sinc) m_src = m_src + stride;
        if (m_dinc) m_dst = m_dst + stride;
        if (!m_cyc) begin
            m_cnt = m_cnt - 16'd1;
            if (m_cnt == 16'd0) begin
                m_done = 1'b1;
                m_active = 1'b0;
            end
        end else begin
            lo = m_cnt[7:0];
            hi = m_cnt[15:8];
            if (lo == 8'd1) begin
                m_cnt = {hi, hi};
                m_reload = 1'b1;
                if (m_area) m_dst = b_dst; else m_src = b_src;
            end else begin
                m_cnt = {hi, lo - 8'd1};
            end
        end
    endtask

    task automatic do_step(input string tag);
        @(negedge clk);
        xfer = 1'b1;
        @(posedge clk);
        #1;
        xfer = 1'b0;
        model_step();
        check_all(tag);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        @(posedge clk);
        #1;
        m_done = 1'b0;
        m_reload = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_src = '0; m_dst = '0; m_cnt = '0; m_active = 1'b0; m_done = 1'b0;
        m_reload = 1'b0; m_word = 1'b0;
        // R1: state straight after reset
        check_all("R1");

        // R3 R4 R5 R7: short normal sequences over size and enable combinations
        for (int n = 1; n <= 5; n++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                do_load(AW'(24'h001000 + n * 16), AW'(24'h004000 + n * 32), CW'(n), 2'b00,
                        cfg[0], cfg[1], cfg[2], 1'b0, 1'b0);
                for (int k = 0; k < n; k++) do_step(k == n - 1 ? "R4" : "R3");
                do_idle("R4");
                do_step("R5");
                do_step("R5");
            end
        end

        // R3: zero count gives 65,536 transfers
        do_load(24'h000100, 24'h000200, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 65536; k++) do_step(k == 65535 ? "R4" : "R3");
        do_step("R5");

        // R6 R8: repeat mode, several reload values, source restored
        for (int h = 1; h <= 4; h++) begin
            do_load(24'h000010, 24'h000800, CW'((h << 8) | 2), 2'b01,
                    1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
            for (int k = 0; k < 3 * h + 4; k++) do_step("R6");
            do_idle("R6");
        end

        // R6 R8: block mode with destination restored; spare code 11 as repeat
        do_load(24'h000300, 24'h000400, 16'h0303, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 10; k++) do_step("R8");
        do_load(24'h000300, 24'h000400, 16'h0201, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) do_step("R8");

        // R6: low byte 0 and high byte 0 mean 256 between reloads
        do_load(24'h000000, 24'h000000, 16'h0000, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 600; k++) do_step("R6");

        // R7: word step across the top of the address range
        do_load(24'hFFFFFF, 24'hFFFFFE, 16'h0004, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) do_step("R7");

        // R9: alignment over every low-bit and size combination
        for (int c = 0; c < 8; c++) begin
            do_load(AW'(24'h000100 | c[0]), AW'(24'h000200 | c[1]), 16'h0002, 2'b00,
                    c[2], 1'b0, 1'b0, 1'b0, 1'b0);
            do_step("R9");
        end

        // R10: load coinciding with a strobe, on a running and an ended sequence
        do_load(24'h000500, 24'h000600, 16'h0009, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        do_step("R3");
        do_load(24'h000700, 24'h000800, 16'h0002, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        do_step("R3");
        do_step("R4");
        do_load(24'h000900, 24'h000A00, 16'h0105, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        do_step("R6");

        // R1: reset in the middle of a sequence
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_src = '0; m_dst = '0; m_cnt = '0; m_active = 1'b0; m_done = 1'b0;
        m_reload = 1'b0; m_word = 1'b0;
        check_all("R1");
        do_step("R5");

        finish_run();
    end

endmodule